// File: doc/BRIEF.md
# PATA PIO / Multiword DMA Strobe Timing Generator

This block drives the active-low read and write strobes of one parallel ATA channel for PIO and multiword DMA bus cycles. Its timing comes from a single packed 32-bit configuration word. Task-file (command register) accesses and data-port accesses each have their own strobe-low count, strobe-high count and first-cycle setup count, all held in that word.

A one-cycle request pulse starts exactly one bus cycle. The request carries three flags: task-file or data port, read or write, and whether it is the first cycle of a burst. The first cycle of a burst gets a setup phase with both strobes high. Every cycle then has an active phase, with the selected strobe low, and a recovery phase, with both strobes high. A one-cycle done pulse closes the cycle.

The configuration word is captured when the request is accepted, so later changes to the word cannot disturb a cycle in flight. Requests that arrive while a cycle is in progress are dropped.

Top module: `ata_strobe_gen`

## Requirements
- R1: While reset is asserted and after its release, dior_n and diow_n are 1, done is 0 and busy is 0 until a request is accepted.
- R2: For a data-port cycle, the strobe is low for bits [8:4]+1 clocks, and the recovery phase that follows lasts bits [3:0]+1 clocks.
- R3: For a task-file cycle, the strobe is low for bits [17:13]+1 clocks, and the recovery phase lasts bits [12:9]+1 clocks.
- R4: When req_first is 1, a setup phase with both strobes high precedes the active phase. It lasts bits [24:22]+1 clocks for a data-port cycle and bits [27:25]+1 clocks for a task-file cycle. When req_first is 0, the strobe goes low in the first clock after acceptance.
- R5: A read (req_write=0) lowers only dior_n and a write (req_write=1) lowers only diow_n. The two strobes are never low together.
- R6: done is high for exactly one clock, in the clock that follows the last recovery clock. busy is high from the clock after acceptance through the done clock, and low in the clock after done.
- R7: The timing word is captured when a request is accepted. Changing it during a cycle leaves that cycle's phase lengths unchanged.
- R8: Bits [21:18], [29:28], 30 and 31 of the timing word have no effect on any phase length.
- R9: A request is accepted only when busy is 0. A request raised while busy is 1 starts no cycle: busy stays low after that cycle's done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request pulse; accepted when busy is 0 |
| req_taskfile | input | 1 | 1 = task-file register access, 0 = data port |
| req_write | input | 1 | 1 = write (diow_n), 0 = read (dior_n) |
| req_first | input | 1 | 1 = first cycle of a burst (adds setup phase) |
| timing_word | input | 32 | Packed timing configuration |
| dior_n | output | 1 | Active-low read strobe |
| diow_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-clock end-of-cycle pulse |
| busy | output | 1 | A bus cycle is in progress |

## Verification
A request driven before clock edge k is accepted at k. The first setup or active clock is visible after edge k, so the bench drives inputs on falling edges and samples one half-period after each rising edge, starting at the falling edge that follows edge k. From those samples it counts the leading high clocks (setup), the low clocks of the selected strobe (active) and the trailing high clocks (recovery). It then expects done at the very next sample and busy low at the sample after that. The expected counts come from fields of the word captured at acceptance. Mid-cycle word changes and requests raised while busy are applied at fixed sample indices within this same window.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 5;

    // field positions inside the timing word
    localparam int DREC_LO = 0;  localparam int DREC_W = 4;
    localparam int DACT_LO = 4;  localparam int DACT_W = 5;
    localparam int TREC_LO = 9;  localparam int TREC_W = 4;
    localparam int TACT_LO = 13; localparam int TACT_W = 5;
    localparam int DSET_LO = 22; localparam int DSET_W = 3;
    localparam int TSET_LO = 25; localparam int TSET_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_ACTIVE, ST_RECOVER, ST_DONE
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] recover;
    } phase_cfg_t;
endpackage

// File: rtl/ata_tmg_decode.sv
module ata_tmg_decode
    import ata_strobe_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              taskfile,
    output phase_cfg_t        cfg
);
    always_comb begin
        cfg = '0;
        if (taskfile) begin
            cfg.setup   = CNT_W'(word[TSET_LO +: TSET_W]);
            cfg.active  = CNT_W'(word[TACT_LO +: TACT_W]);
            cfg.recover = CNT_W'(word[TREC_LO +: TREC_W]);
        end else begin
            cfg.setup   = CNT_W'(word[DSET_LO +: DSET_W]);
            cfg.active  = CNT_W'(word[DACT_LO +: DACT_W]);
            cfg.recover = CNT_W'(word[DREC_LO +: DREC_W]);
        end
    end
endmodule

// File: rtl/ata_phase_cnt.sv
module ata_phase_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
    import ata_strobe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_taskfile,
    input  logic              req_write,
    input  logic              req_first,
    input  logic [WORD_W-1:0] timing_word,
    output logic              dior_n,
    output logic              diow_n,
    output logic              done,
    output logic              busy
);
    typedef struct packed {
        phase_e     state;
        phase_cfg_t cfg;
        logic       wr;
    } ctl_t;

    ctl_t       ctl_d, ctl_q;
    phase_cfg_t dec_cfg;
    logic       cnt_load, cnt_zero;
    logic [CNT_W-1:0] cnt_val;

    ata_tmg_decode u_dec (
        .word     (timing_word),
        .taskfile (req_taskfile),
        .cfg      (dec_cfg)
    );

    ata_phase_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    always_comb begin
        ctl_d    = ctl_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (ctl_q.state)
            ST_IDLE: if (req_valid) begin
                ctl_d.cfg = dec_cfg;
                ctl_d.wr  = req_write;
                cnt_load  = 1'b1;
                if (req_first) begin
                    ctl_d.state = ST_SETUP;
                    cnt_val     = dec_cfg.setup;
                end else begin
                    ctl_d.state = ST_ACTIVE;
                    cnt_val     = dec_cfg.active;
                end
            end
            ST_SETUP: if (cnt_zero) begin
                ctl_d.state = ST_ACTIVE;
                cnt_load    = 1'b1;
                cnt_val     = ctl_q.cfg.active;
            end
            ST_ACTIVE: if (cnt_zero) begin
                ctl_d.state = ST_RECOVER;
                cnt_load    = 1'b1;
                cnt_val     = ctl_q.cfg.recover;
            end
            ST_RECOVER: if (cnt_zero) ctl_d.state = ST_DONE;
            ST_DONE:    ctl_d.state = ST_IDLE;
            default:    ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.cfg   <= '0;
            ctl_q.wr    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dior_n = !((ctl_q.state == ST_ACTIVE) && !ctl_q.wr);
    assign diow_n = !((ctl_q.state == ST_ACTIVE) &&  ctl_q.wr);
    assign done   = (ctl_q.state == ST_DONE);
    assign busy   = (ctl_q.state != ST_IDLE);

    // R5: strobes mutually exclusive
    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n));
    // R6: done lasts one clock and follows recovery
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
    p_done_after_rec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ctl_q.state) == ST_RECOVER);
    // R7: captured timing is held while a cycle runs
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ctl_q.cfg));
    // R1: strobes high whenever idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dior_n && diow_n && !done));
    // R9: idle entered only through done
    p_idle_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));
endmodule

// File: tb/ata_strobe_gen_test.sv
module ata_strobe_gen_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_taskfile = 1'b0, req_write = 1'b0, req_first = 1'b0;
    logic [31:0] timing_word = 32'h0;
    logic dior_n, diow_n, done, busy;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ata_strobe_gen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_taskfile(req_taskfile), .req_write(req_write),
        .req_first(req_first), .timing_word(timing_word),
        .dior_n(dior_n), .diow_n(diow_n), .done(done), .busy(busy)
    );

    function automatic int exp_setup(logic [31:0] w, bit tf, bit first);
        if (!first) return 0;
        return tf ? int'(w[27:25]) + 1 : int'(w[24:22]) + 1;
    endfunction
    function automatic int exp_act(logic [31:0] w, bit tf);
        return tf ? int'(w[17:13]) + 1 : int'(w[8:4]) + 1;
    endfunction
    function automatic int exp_rec(logic [31:0] w, bit tf);
        return tf ? int'(w[12:9]) + 1 : int'(w[3:0]) + 1;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one bus cycle; optional mid-cycle word change and busy request
    task automatic run_cycle(logic [31:0] w, bit tf, bit wr, bit first,
                             bit mutate, bit poke, string tag);
        int s = 0, a = 0, r = 0, n = 0, both = 0, wrong = 0;
        bit seen_low = 0, seen_done = 0;
        int es = exp_setup(w, tf, first);
        int ea = exp_act(w, tf);
        int er = exp_rec(w, tf);
        @(negedge clk);
        timing_word = w; req_taskfile = tf; req_write = wr; req_first = first;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!seen_done && n < 200) begin
            logic sel = wr ? diow_n : dior_n;
            logic oth = wr ? dior_n : diow_n;
            if (done) seen_done = 1;
            else if (!sel) begin seen_low = 1; a++; end
            else if (!seen_low) s++;
            else r++;
            if (!oth) wrong++;
            if (!dior_n && !diow_n) both++;
            if (!seen_done && !busy) both++;
            if (mutate && n == 1) timing_word = ~w;
            if (poke && n == 2) begin
                req_valid = 1'b1; req_first = 1'b1; req_write = ~wr;
            end
            if (poke && n == 3) req_valid = 1'b0;
            n++;
            if (!seen_done) @(negedge clk);
        end
        chk(seen_done, {tag, " R6 done seen"}, seen_done, 1);
        chk(s == es, {tag, " R4 setup clocks"}, s, es);
        chk(a == ea, {tag, tf ? " R3 tf active" : " R2 data active"}, a, ea);
        chk(r == er, {tag, tf ? " R3 tf recover" : " R2 data recover"}, r, er);
        chk(wrong == 0 && both == 0, {tag, " R5 strobe select/busy"}, wrong + both, 0);
        @(negedge clk);
        chk(!busy && !done && dior_n && diow_n, {tag, " R6 idle after done"}, busy, 0);
        if (poke) begin
            @(negedge clk);
            chk(!busy && dior_n && diow_n, {tag, " R9 busy request dropped"}, busy, 0);
        end
    endtask

    initial begin
        logic [31:0] w;
        void'($urandom(32'd1234));
        #1;
        chk(dior_n && diow_n && !done && !busy, "R1 in reset", busy, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dior_n && diow_n && !done && !busy, "R1 after reset", busy, 0);

        // directed
        run_cycle(32'h0000_0000, 0, 0, 0, 0, 0, "min data read");
        run_cycle(32'h0fff_ffff, 1, 1, 1, 0, 0, "max tf write");
        run_cycle(32'h0fff_ffff, 0, 0, 1, 0, 0, "max data read");
        run_cycle(32'h06414e31, 1, 0, 1, 0, 0, "typ tf read");
        run_cycle(32'h06414e31, 0, 1, 0, 0, 0, "typ data write");
        // R7: word changes mid-cycle
        run_cycle(32'h0281_3c57, 0, 1, 1, 1, 0, "R7 data mutate");
        run_cycle(32'h0281_3c57, 1, 0, 1, 1, 0, "R7 tf mutate");
        // R8: ignored bits set vs clear give the same counts (expected from low bits only)
        run_cycle(32'hF03C_0000 | 32'h0281_3c57, 0, 0, 1, 0, 0, "R8 ignored bits data");
        run_cycle(32'hF03C_0000 | 32'h0281_3c57, 1, 1, 1, 0, 0, "R8 ignored bits tf");
        // R9: request while busy
        run_cycle(32'h0123_4567, 0, 0, 1, 0, 1, "R9 poke data");
        run_cycle(32'h0123_4567, 1, 1, 0, 0, 1, "R9 poke tf");

        // random
        for (int i = 0; i < 40; i++) begin
            w = $urandom;
            run_cycle(w, 1'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 1'($urandom), "rand");
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule